// File: doc/BRIEF.md
# Configurable Pseudorandom Feedback Shift Register

This block is an n-bit linear feedback shift register. It produces a pseudorandom bit stream and makes its whole state visible. One tap mask parameter encodes the feedback polynomial. A build-time choice sets how that mask is applied:

- **External XOR:** a single XOR of the tapped stages feeds the first stage.
- **Distributed XOR:** the last stage feeds the first stage and is also XORed into each tapped stage.

With a primitive polynomial, either form steps through every non-zero state before it repeats.

Software or a neighbouring block can start the sequence at any phase by pulsing a seed-load strobe with a value on the seed bus. Enable gates the advance, so the stream can be paused without losing its place. Several things keep the register out of the all-zeros lock-up state:

- the reset value is a non-zero constant;
- a seed of zero is replaced by a fixed non-zero fallback;
- any computed next state of zero is replaced by the same fallback.

Top module: `lfsr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes the parameter `RESET_VAL`, a non-zero constant.
- R2: When `enable` and `loadSeed` are both low at an edge, `stateOut` and `outBit` keep their values.
- R3: With `FORM` set to the external-XOR variant, an enabled edge moves each `stateOut[i-1]` into `stateOut[i]`. `stateOut[0]` is stage 1 and `stateOut[WIDTH-1]` is the last stage. The new `stateOut[0]` is the XOR of every `stateOut[k]` whose `TAPS[k]` is 1.
- R4: With `FORM` set to the distributed-XOR variant, an enabled edge sets the new `stateOut[0]` to the old `stateOut[WIDTH-1]`. For i ≥ 1, the new `stateOut[i]` is the old `stateOut[i-1]` XOR (`TAPS[i-1]` AND old `stateOut[WIDTH-1]`). `TAPS[WIDTH-1]` is not used in this form.
- R5: `outBit` always equals `stateOut[WIDTH-1]`, the bit that the next advance shifts out.
- R6: A high `loadSeed` at an edge loads `seedIn` into the state, whatever the level of `enable`. Loading takes priority over advancing.
- R7: A seed of zero loads the parameter `FALLBACK_VAL` (non-zero) in its place.
- R8: Outside reset the state is never all zeros. If the feedback would produce zero, `FALLBACK_VAL` is loaded instead.
- R9: With a primitive mask, both forms return to a state after exactly 2^WIDTH − 1 advances, and both visit the same set of states (every non-zero value).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Advance the sequence by one step this edge |
| loadSeed | input | 1 | Load the seed bus this edge (wins over enable) |
| seedIn | input | WIDTH | Seed value; zero is replaced by the fallback |
| outBit | output | 1 | Serial output, the last stage |
| stateOut | output | WIDTH | Full register state, bit 0 is stage 1 |

## Verification
The bench builds the block at WIDTH = 5. It makes three instances:

- the external-XOR form with mask 0x14, which is primitive for both forms;
- the distributed-XOR form with the same mask;
- the external-XOR form with the non-primitive mask 0x02, whose feedback can reach zero.

At width 5, a full period of 31 steps fits easily in the run. The bench sweeps all 31 non-zero seeds through a complete period in both forms and compares every step with an arithmetic model. It also checks that the two state sets are identical. The third instance makes the zero-state guard reachable from a single loaded seed.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  typedef enum logic {
    FORM_EXT = 1'b0,
    FORM_DIST = 1'b1
  } lfsrForm_e;

  typedef struct packed {
    logic load;
    logic step;
  } lfsrStrobe_t;

endpackage

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl #(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] FALLBACK_VAL = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic loadSeed,
  input  logic [WIDTH-1:0] seedIn,
  output lfsr_pkg::lfsrStrobe_t strobe,
  output logic [WIDTH-1:0] seedSel
);

  localparam logic [WIDTH-1:0] ZERO_STATE = '0;

  always_comb begin
    strobe.load = loadSeed;
    strobe.step = enable & ~loadSeed;
  end

  always_comb begin
    if (seedIn == ZERO_STATE) seedSel = FALLBACK_VAL;
    else seedSel = seedIn;
  end

  // a load request never carries a zero seed into the datapath
  p_seed_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.load |-> (seedSel != ZERO_STATE));

  // a step is never issued in a cycle that loads
  p_load_wins_r6: assert property (@(posedge clk) disable iff (rst)
    loadSeed |-> !strobe.step);

endmodule

// File: rtl/lfsr_datapath.sv
module lfsr_datapath #(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter lfsr_pkg::lfsrForm_e FORM = lfsr_pkg::FORM_EXT,
  parameter logic [WIDTH-1:0] RESET_VAL = {{(WIDTH-1){1'b0}}, 1'b1},
  parameter logic [WIDTH-1:0] FALLBACK_VAL = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic clk,
  input  logic rst,
  input  lfsr_pkg::lfsrStrobe_t strobe,
  input  logic [WIDTH-1:0] seedSel,
  output logic [WIDTH-1:0] stateQ
);

  localparam int unsigned MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] ZERO_STATE = '0;
  localparam logic [WIDTH-1:0] SAFE_RESET =
    (RESET_VAL == ZERO_STATE) ? FALLBACK_VAL : RESET_VAL;

  logic [WIDTH-1:0] nextRaw;
  logic [WIDTH-1:0] nextSafe;
  logic lastStage;

  assign lastStage = stateQ[MSB];

  generate
    if (FORM == lfsr_pkg::FORM_EXT) begin : g_ext
      logic feedBit;
      assign feedBit = ^(stateQ & TAPS);
      assign nextRaw = {stateQ[MSB-1:0], feedBit};
    end else begin : g_dist
      assign nextRaw[0] = lastStage;
      for (genvar i = 1; i < WIDTH; i++) begin : g_stage
        assign nextRaw[i] = stateQ[i-1] ^ (TAPS[i-1] & lastStage);
      end
    end
  endgenerate

  assign nextSafe = (nextRaw == ZERO_STATE) ? FALLBACK_VAL : nextRaw;

  always_ff @(posedge clk) begin
    if (rst) stateQ <= SAFE_RESET;
    else if (strobe.load) stateQ <= seedSel;
    else if (strobe.step) stateQ <= nextSafe;
  end

  // lock-up state is never held outside reset
  p_never_zero_r8: assert property (@(posedge clk) disable iff (rst)
    stateQ != ZERO_STATE);

  // no strobe, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!strobe.load && !strobe.step) |=> $stable(stateQ));

  // the control never raises both strobes
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.load, strobe.step}));

  generate
    if (FORM == lfsr_pkg::FORM_EXT) begin : g_chk_ext
      // upper stages copy their lower neighbours, unless the guard fired
      p_chain_r3: assert property (@(posedge clk) disable iff (rst)
        strobe.step |=> ((stateQ[MSB:1] == $past(stateQ[MSB-1:0]))
                         || (stateQ == FALLBACK_VAL)));
    end else begin : g_chk_dist
      // stage 1 receives the old last stage
      p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        strobe.step |=> (stateQ[0] == $past(stateQ[MSB])));
    end
  endgenerate

endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen #(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter lfsr_pkg::lfsrForm_e FORM = lfsr_pkg::FORM_EXT,
  parameter logic [WIDTH-1:0] RESET_VAL = {{(WIDTH-1){1'b0}}, 1'b1},
  parameter logic [WIDTH-1:0] FALLBACK_VAL = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic loadSeed,
  input  logic [WIDTH-1:0] seedIn,
  output logic outBit,
  output logic [WIDTH-1:0] stateOut
);

  lfsr_pkg::lfsrStrobe_t strobe;
  logic [WIDTH-1:0] seedSel;

  lfsr_ctrl #(
    .WIDTH(WIDTH),
    .FALLBACK_VAL(FALLBACK_VAL)
  ) u_ctrl (
    .clk(clk),
    .rst(rst),
    .enable(enable),
    .loadSeed(loadSeed),
    .seedIn(seedIn),
    .strobe(strobe),
    .seedSel(seedSel)
  );

  lfsr_datapath #(
    .WIDTH(WIDTH),
    .TAPS(TAPS),
    .FORM(FORM),
    .RESET_VAL(RESET_VAL),
    .FALLBACK_VAL(FALLBACK_VAL)
  ) u_datapath (
    .clk(clk),
    .rst(rst),
    .strobe(strobe),
    .seedSel(seedSel),
    .stateQ(stateOut)
  );

  assign outBit = stateOut[WIDTH-1];

  // port-level load: the seed or its non-zero substitute appears next cycle
  p_seed_load_r6: assert property (@(posedge clk) disable iff (rst)
    loadSeed |=> (stateOut == (($past(seedIn) == '0) ? FALLBACK_VAL : $past(seedIn))));

endmodule

// File: tb/lfsr_gen_tb.sv
module lfsr_gen_tb;

  localparam int W = 5;
  localparam int PERIOD = (1 << W) - 1;
  localparam logic [W-1:0] MASK = 5'h14;
  localparam logic [W-1:0] BAD_MASK = 5'h02;
  localparam logic [W-1:0] RST_V = 5'h0B;
  localparam logic [W-1:0] FB_V = 5'h15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic loadSeed = 1'b0;
  logic [W-1:0] seedIn = '0;
  logic outE, outD, outB;
  logic [W-1:0] stE, stD, stB;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lfsr_gen #(.WIDTH(W), .TAPS(MASK), .FORM(lfsr_pkg::FORM_EXT),
             .RESET_VAL(RST_V), .FALLBACK_VAL(FB_V)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .loadSeed(loadSeed),
    .seedIn(seedIn), .outBit(outE), .stateOut(stE));

  lfsr_gen #(.WIDTH(W), .TAPS(MASK), .FORM(lfsr_pkg::FORM_DIST),
             .RESET_VAL(RST_V), .FALLBACK_VAL(FB_V)) u_dut_dist (
    .clk(clk), .rst(rst), .enable(enable), .loadSeed(loadSeed),
    .seedIn(seedIn), .outBit(outD), .stateOut(stD));

  lfsr_gen #(.WIDTH(W), .TAPS(BAD_MASK), .FORM(lfsr_pkg::FORM_EXT),
             .RESET_VAL(RST_V), .FALLBACK_VAL(FB_V)) u_dut_guard (
    .clk(clk), .rst(rst), .enable(enable), .loadSeed(loadSeed),
    .seedIn(seedIn), .outBit(outB), .stateOut(stB));

  // external form: parity of tapped bits enters at the bottom
  function automatic logic [W-1:0] modelExt(logic [W-1:0] s, logic [W-1:0] m);
    int ones = 0;
    logic [W-1:0] r;
    for (int k = 0; k < W; k++) if (m[k] && s[k]) ones++;
    r = (s << 1) | ((ones % 2) == 1 ? 1 : 0);
    if (r == 0) r = FB_V;
    return r;
  endfunction

  // distributed form: multiply by x modulo the mask polynomial
  function automatic logic [W-1:0] modelDist(logic [W-1:0] s, logic [W-1:0] m);
    logic [W-1:0] r;
    logic [W-1:0] low;
    low = m & ~(1 << (W - 1));
    r = s << 1;
    if (s[W-1]) r = r ^ ((low << 1) | 1);
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(logic en, logic ld, logic [W-1:0] sd);
    enable = en;
    loadSeed = ld;
    seedIn = sd;
    @(posedge clk);
    #5;
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] expE, expD, startE, startD;
    bit visE [PERIOD+1];
    bit visD [PERIOD+1];
    int firstE, firstD;

    rst = 1'b1;
    repeat (3) cycle(1'b1, 1'b0, 5'h07);
    check(stE == RST_V, "R1 reset ext", stE, RST_V);
    check(stD == RST_V, "R1 reset dist", stD, RST_V);
    check(outE == RST_V[W-1], "R5 out at reset", outE, RST_V[W-1]);
    rst = 1'b0;

    // R2: idle edges with a busy seed bus
    for (int k = 0; k < 4; k++) begin
      cycle(1'b0, 1'b0, 5'(k * 7 + 3));
      check(stE == RST_V && outE == RST_V[W-1], "R2 hold ext", stE, RST_V);
      check(stD == RST_V && outD == RST_V[W-1], "R2 hold dist", stD, RST_V);
    end

    // full period from reset value; R3 R4 R5 R8 R9
    for (int k = 0; k <= PERIOD; k++) begin
      visE[k] = 1'b0;
      visD[k] = 1'b0;
    end
    expE = RST_V; expD = RST_V; startE = RST_V; startD = RST_V;
    firstE = 0; firstD = 0;
    for (int k = 1; k <= PERIOD; k++) begin
      check(outE == expE[W-1], "R5 out ext", outE, expE[W-1]);
      check(outD == expD[W-1], "R5 out dist", outD, expD[W-1]);
      visE[stE] = 1'b1;
      visD[stD] = 1'b1;
      cycle(1'b1, 1'b0, '0);
      expE = modelExt(expE, MASK);
      expD = modelDist(expD, MASK);
      check(stE == expE, "R3 ext step", stE, expE);
      check(stD == expD, "R4 dist step", stD, expD);
      check(stE != 0 && stD != 0, "R8 nonzero", stE, 1);
      if (firstE == 0 && stE == startE) firstE = k;
      if (firstD == 0 && stD == startD) firstD = k;
    end
    check(firstE == PERIOD, "R9 period ext", firstE, PERIOD);
    check(firstD == PERIOD, "R9 period dist", firstD, PERIOD);
    for (int v = 0; v <= PERIOD; v++) begin
      check(visE[v] == visD[v], "R9 same set", visE[v], visD[v]);
      check(visE[v] == (v != 0), "R9 all nonzero", visE[v], (v != 0));
    end

    // seed sweep, load with enable high; R6 R3 R4
    for (int sd = 1; sd <= PERIOD; sd++) begin
      cycle(1'b1, 1'b1, 5'(sd));
      check(stE == 5'(sd), "R6 seed ext", stE, sd);
      check(stD == 5'(sd), "R6 seed dist", stD, sd);
      expE = 5'(sd); expD = 5'(sd);
      for (int k = 0; k < PERIOD; k++) begin
        cycle(1'b1, 1'b0, '0);
        expE = modelExt(expE, MASK);
        expD = modelDist(expD, MASK);
        check(stE == expE, "R3 sweep", stE, expE);
        check(stD == expD, "R4 sweep", stD, expD);
      end
      check(stE == 5'(sd) && stD == 5'(sd), "R9 return to seed", stE, sd);
    end

    // load with enable low
    cycle(1'b0, 1'b1, 5'h19);
    check(stE == 5'h19 && stD == 5'h19, "R6 load idle", stE, 5'h19);
    cycle(1'b0, 1'b0, 5'h02);
    check(stE == 5'h19, "R2 hold after load", stE, 5'h19);

    // zero seed substitution
    cycle(1'b1, 1'b1, 5'h00);
    check(stE == FB_V, "R7 zero seed ext", stE, FB_V);
    check(stD == FB_V, "R7 zero seed dist", stD, FB_V);
    cycle(1'b0, 1'b1, 5'h00);
    check(stB == FB_V, "R7 zero seed idle", stB, FB_V);

    // guard: non-primitive mask from 10000 would feed zero
    cycle(1'b0, 1'b1, 5'h10);
    check(stB == 5'h10 && outB == 1'b1, "R5 guard preload", stB, 5'h10);
    cycle(1'b1, 1'b0, '0);
    check(stB == FB_V, "R8 zero guard", stB, FB_V);

    // reset in mid-run
    cycle(1'b1, 1'b0, '0);
    rst = 1'b1;
    cycle(1'b1, 1'b1, 5'h03);
    check(stE == RST_V && stD == RST_V && stB == RST_V, "R1 mid reset", stE, RST_V);
    rst = 1'b0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule